// File: doc/BRIEF.md
# Text Cursor Generator

This block decides, for every character clock of a character-cell display controller, whether the hardware text cursor is drawn in the current cell. It compares the memory address that the timing generator presents with a programmed 14-bit cursor location. It also checks that the row address within the character row lies inside a programmed inclusive scanline window, and that display enable is active. A 2-bit mode field selects a steady cursor, a suppressed cursor, or a cursor that blinks at one of two rates.

Blinking is driven by a 5-bit frame counter that advances once per frame on a strobe from the timing generator. The result is a single registered enable. External logic combines it with the video data, for example by inverting or overriding the serialised pixels of the matching cell.

Top module: `txt_cursor_gen`

## Requirements
- R1: The cursor location is formed from `cur_addr_hi[5:0]` as address bits 13:8 and `cur_addr_lo[7:0]` as bits 7:0. The cursor is drawn only while `mem_addr` equals that location exactly.
- R2: The cursor is drawn only while `row_addr` lies in the inclusive range from `cur_start_cfg[4:0]` (first scanline) to `cur_end[4:0]` (last scanline).
- R3: Mode value 01 in `cur_start_cfg[6:5]` keeps `cursor_en` low at all times.
- R4: Mode value 00 gives a steady cursor: `cursor_en` is high whenever address, row window and display enable all match, in every frame.
- R5: While `disp_en` is low, `cursor_en` is low.
- R6: When the first scanline is greater than the last scanline, no row matches and the cursor is never drawn.
- R7: A 5-bit frame counter resets to 0, advances by one in every cycle in which `frame_strobe` is high, and wraps from 31 to 0.
- R8: Mode value 10 draws the cursor only while frame counter bit 3 is 0, which gives a blink period of 16 frames.
- R9: Mode value 11 draws the cursor only while frame counter bit 4 is 0, which gives a blink period of 32 frames.
- R10: `cursor_en` is registered. It reflects the inputs sampled at the previous rising clock edge, and it uses the frame counter value from before any increment caused by a strobe in that same cycle.
- R11: While `rst_n` is low, `cursor_en` is low. After reset the frame counter starts at 0, so a blinking cursor starts in its visible phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | input | 14 | Current display memory address from the timing generator |
| row_addr | input | 5 | Scanline index within the current character row |
| disp_en | input | 1 | High during the visible part of the raster |
| frame_strobe | input | 1 | One-cycle pulse at the start of each vertical sync |
| cur_addr_hi | input | 6 | Cursor location bits 13:8 |
| cur_addr_lo | input | 8 | Cursor location bits 7:0 |
| cur_start_cfg | input | 7 | Bits 4:0 first cursor scanline, bits 6:5 cursor mode |
| cur_end | input | 5 | Last cursor scanline |
| cursor_en | output | 1 | Registered cursor enable for the current cell |

## Verification
The frame strobe and a cursor hit can fall in the same clock cycle. In that cycle the output must be judged on the frame count from before the increment, not on the incremented count. The bench provokes this by walking the counter through many frames and pulsing the strobe on the very cycle that presents the matching cell. It does this in both blink modes, including the 7-to-8 and 15-to-16 transitions where the blink phase flips. A model of the frame count kept in the bench is advanced only after each comparison, so an implementation that reads the already-incremented count disagrees at those phase flips.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // Cursor display mode, taken from the two bits above the first-scanline field
    typedef enum logic [1:0] {
        CM_STEADY     = 2'b00,
        CM_HIDDEN     = 2'b01,
        CM_BLINK_FAST = 2'b10,
        CM_BLINK_SLOW = 2'b11
    } cur_mode_e;

    // Output state of the cursor enable register
    typedef enum logic {
        CE_IDLE   = 1'b0,
        CE_ACTIVE = 1'b1
    } ce_state_e;

endpackage

// File: rtl/cursor_frame_ctr.sv
module cursor_frame_ctr
    import cursor_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int FAST_BIT = 3,
    parameter int SLOW_BIT = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_strobe,
    input  cur_mode_e mode,
    output logic      blink_ok
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] frame_cnt;

    // Free-running frame counter, one step per vertical sync start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (frame_strobe) begin
            frame_cnt <= frame_cnt + CNT_ONE;
        end
    end

    // Visibility permitted by the selected mode for the current frame
    always_comb begin
        unique case (mode)
            CM_STEADY:     blink_ok = 1'b1;
            CM_HIDDEN:     blink_ok = 1'b0;
            CM_BLINK_FAST: blink_ok = ~frame_cnt[FAST_BIT];
            CM_BLINK_SLOW: blink_ok = ~frame_cnt[SLOW_BIT];
            default:       blink_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/cursor_addr_cmp.sv
module cursor_addr_cmp #(
    parameter int ADDR_W = 14,
    parameter int LO_W   = 8
) (
    input  logic [ADDR_W-1:0]      mem_addr,
    input  logic [ADDR_W-LO_W-1:0] cur_hi,
    input  logic [LO_W-1:0]        cur_lo,
    output logic                   addr_hit
);

    localparam int HI_W = ADDR_W - LO_W;

    logic [ADDR_W-1:0] cur_full;
    logic [ADDR_W-1:0] bit_eq;

    assign cur_full = {cur_hi, cur_lo};

    // Per-bit equality, reduced afterwards
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign bit_eq[b] = ~(mem_addr[b] ^ cur_full[b]);
    end

    assign addr_hit = &bit_eq;

    if (HI_W < 1) begin : g_bad_split
        initial $error("cursor_addr_cmp: high field must be at least one bit");
    end

endmodule

// File: rtl/cursor_row_win.sv
module cursor_row_win #(
    parameter int ROW_W = 5
) (
    input  logic [ROW_W-1:0] row_addr,
    input  logic [ROW_W-1:0] first_row,
    input  logic [ROW_W-1:0] last_row,
    output logic             row_hit
);

    logic above_first;
    logic below_last;

    // Inclusive window; an inverted window cannot satisfy both sides
    assign above_first = (row_addr >= first_row);
    assign below_last  = (row_addr <= last_row);
    assign row_hit     = above_first & below_last;

endmodule

// File: rtl/txt_cursor_gen.sv
module txt_cursor_gen
    import cursor_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int LO_W     = 8,
    parameter int ROW_W    = 5,
    parameter int CNT_W    = 5,
    parameter int FAST_BIT = 3,
    parameter int SLOW_BIT = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      mem_addr,
    input  logic [ROW_W-1:0]       row_addr,
    input  logic                   disp_en,
    input  logic                   frame_strobe,
    input  logic [ADDR_W-LO_W-1:0] cur_addr_hi,
    input  logic [LO_W-1:0]        cur_addr_lo,
    input  logic [ROW_W+1:0]       cur_start_cfg,
    input  logic [ROW_W-1:0]       cur_end,
    output logic                   cursor_en
);

    cur_mode_e  mode_w;
    logic       blink_ok;
    logic       addr_hit;
    logic       row_hit;
    logic       cell_hit;
    ce_state_e  state_q;
    ce_state_e  state_d;

    assign mode_w = cur_mode_e'(cur_start_cfg[ROW_W+1:ROW_W]);

    cursor_frame_ctr #(
        .CNT_W    (CNT_W),
        .FAST_BIT (FAST_BIT),
        .SLOW_BIT (SLOW_BIT)
    ) i_frame_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_strobe (frame_strobe),
        .mode         (mode_w),
        .blink_ok     (blink_ok)
    );

    cursor_addr_cmp #(
        .ADDR_W (ADDR_W),
        .LO_W   (LO_W)
    ) i_addr_cmp (
        .mem_addr (mem_addr),
        .cur_hi   (cur_addr_hi),
        .cur_lo   (cur_addr_lo),
        .addr_hit (addr_hit)
    );

    cursor_row_win #(
        .ROW_W (ROW_W)
    ) i_row_win (
        .row_addr  (row_addr),
        .first_row (cur_start_cfg[ROW_W-1:0]),
        .last_row  (cur_end),
        .row_hit   (row_hit)
    );

    assign cell_hit = addr_hit & row_hit & disp_en & blink_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->ACTIVE on a hit, ACTIVE->IDLE on a miss
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CE_IDLE:   if (cell_hit)  state_d = CE_ACTIVE;
            CE_ACTIVE: if (!cell_hit) state_d = CE_IDLE;
            default:   state_d = CE_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            CE_ACTIVE: cursor_en = 1'b1;
            CE_IDLE:   cursor_en = 1'b0;
            default:   cursor_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/txt_cursor_gen_chk.sv
module txt_cursor_gen_chk #(
    parameter int ADDR_W = 14,
    parameter int LO_W   = 8,
    parameter int ROW_W  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic [ROW_W-1:0]       row_addr,
    input logic                   disp_en,
    input logic [ADDR_W-LO_W-1:0] cur_addr_hi,
    input logic [LO_W-1:0]        cur_addr_lo,
    input logic [ROW_W+1:0]       cur_start_cfg,
    input logic [ROW_W-1:0]       cur_end,
    input logic                   cursor_en
);

    AST_ADDR_MISS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != {cur_addr_hi, cur_addr_lo}) |=> !cursor_en); // R1

    AST_ROW_OUTSIDE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_addr < cur_start_cfg[ROW_W-1:0]) || (row_addr > cur_end)) |=> !cursor_en); // R2

    AST_HIDDEN_MODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_start_cfg[ROW_W+1:ROW_W] == 2'b01) |=> !cursor_en); // R3

    AST_STEADY_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_start_cfg[ROW_W+1:ROW_W] == 2'b00) && disp_en
         && (mem_addr == {cur_addr_hi, cur_addr_lo})
         && (row_addr >= cur_start_cfg[ROW_W-1:0]) && (row_addr <= cur_end))
        |=> cursor_en); // R4

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !cursor_en); // R5

    AST_INVERTED_WINDOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_start_cfg[ROW_W-1:0] > cur_end) |=> !cursor_en); // R6

endmodule

bind txt_cursor_gen txt_cursor_gen_chk #(
    .ADDR_W (ADDR_W),
    .LO_W   (LO_W),
    .ROW_W  (ROW_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_addr      (mem_addr),
    .row_addr      (row_addr),
    .disp_en       (disp_en),
    .cur_addr_hi   (cur_addr_hi),
    .cur_addr_lo   (cur_addr_lo),
    .cur_start_cfg (cur_start_cfg),
    .cur_end       (cur_end),
    .cursor_en     (cursor_en)
);

// File: tb/test_txt_cursor_gen.sv
module test_txt_cursor_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mem_addr = '0;
    logic [4:0]  row_addr = '0;
    logic        disp_en = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [5:0]  cur_addr_hi = '0;
    logic [7:0]  cur_addr_lo = '0;
    logic [6:0]  cur_start_cfg = '0;
    logic [4:0]  cur_end = '0;
    logic        cursor_en;

    int   n_checks = 0;
    int   n_errors = 0;
    int   fc = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    txt_cursor_gen i_txt_cursor_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .mem_addr      (mem_addr),
        .row_addr      (row_addr),
        .disp_en       (disp_en),
        .frame_strobe  (frame_strobe),
        .cur_addr_hi   (cur_addr_hi),
        .cur_addr_lo   (cur_addr_lo),
        .cur_start_cfg (cur_start_cfg),
        .cur_end       (cur_end),
        .cursor_en     (cursor_en)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: cursor_en=%0b expected %0b (ma=%0h ra=%0d de=%0b mode=%0d frame=%0d)",
                     req, $time, act, exp, mem_addr, row_addr, disp_en,
                     cur_start_cfg[6:5], fc);
        end
    endtask

    function automatic logic model(input logic [13:0] ma, input logic [4:0] ra,
                                   input logic de, input int frame);
        logic [1:0] md;
        logic       vis;
        md = cur_start_cfg[6:5];
        case (md)
            2'd0:    vis = 1'b1;
            2'd1:    vis = 1'b0;
            2'd2:    vis = ((frame / 8) % 2) == 0;
            default: vis = ((frame / 16) % 2) == 0;
        endcase
        return de && (ma == {cur_addr_hi, cur_addr_lo})
               && (ra >= cur_start_cfg[4:0]) && (ra <= cur_end) && vis;
    endfunction

    // One character clock: drive at the falling edge, judge after the next rising edge
    task automatic step(input logic [13:0] ma, input logic [4:0] ra, input logic de,
                        input logic fs, input string req);
        logic exp;
        @(negedge clk);
        mem_addr     = ma;
        row_addr     = ra;
        disp_en      = de;
        frame_strobe = fs;
        exp = model(ma, ra, de, fc);
        @(posedge clk);
        #1;
        check(cursor_en, exp, req);
        if (fs) fc = (fc + 1) % 32;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [13:0] cur;
        string       tag;
        // R11: output low while reset is held, even with a full hit on the inputs
        cur_addr_hi   = 6'h2A;
        cur_addr_lo   = 8'h5C;
        cur_start_cfg = {2'b00, 5'd0};
        cur_end       = 5'd31;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            mem_addr = {cur_addr_hi, cur_addr_lo};
            disp_en  = 1'b1;
            frame_strobe = 1'b1;
            @(posedge clk);
            #1;
            check(cursor_en, 1'b0, "R11");
        end
        @(negedge clk);
        frame_strobe = 1'b0;
        rst_n = 1'b1;
        fc = 0;
        cur = {cur_addr_hi, cur_addr_lo};

        // R11/R8: after reset the counter is 0, so a fast blink starts visible
        cur_start_cfg = {2'b10, 5'd0};
        step(cur, 5'd3, 1'b1, 1'b0, "R11");

        // R1: every single-bit mismatch of the address misses, exact match hits
        cur_start_cfg = {2'b00, 5'd0};
        for (int b = 0; b < 14; b++) begin
            step(cur ^ (14'd1 << b), 5'd2, 1'b1, 1'b0, "R1");
            step(cur, 5'd2, 1'b1, 1'b0, "R1");
        end

        // R5: blanking suppresses an otherwise full hit
        step(cur, 5'd2, 1'b0, 1'b0, "R5");
        step(cur, 5'd2, 1'b1, 1'b0, "R5");
        step(cur, 5'd2, 1'b0, 1'b0, "R5");

        // R2/R3/R4/R6: sweep mode, window bounds and row over a small range
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                for (int e = 0; e < 8; e++) begin
                    @(negedge clk);
                    cur_start_cfg = {2'(m), 5'(s)};
                    cur_end       = 5'(e);
                    for (int r = 0; r < 9; r++) begin
                        if (m == 1)       tag = "R3";
                        else if (s > e)   tag = "R6";
                        else if (r < s || r > e) tag = "R2";
                        else              tag = "R4";
                        step(cur, 5'(r), 1'b1, 1'b0, tag);
                    end
                end
            end
        end

        // R2: full-width row bounds
        cur_start_cfg = {2'b00, 5'd30};
        cur_end       = 5'd31;
        step(cur, 5'd29, 1'b1, 1'b0, "R2");
        step(cur, 5'd30, 1'b1, 1'b0, "R2");
        step(cur, 5'd31, 1'b1, 1'b0, "R2");

        // R7/R8/R10: fast blink over 40 frames, strobe coinciding with the hit cell
        cur_start_cfg = {2'b10, 5'd0};
        cur_end       = 5'd7;
        for (int f = 0; f < 40; f++) begin
            step(cur, 5'd4, 1'b1, 1'b1, "R10");
            step(cur, 5'd4, 1'b1, 1'b0, "R8");
            step(cur + 14'd1, 5'd4, 1'b1, 1'b0, "R8");
        end

        // R7/R9/R10: slow blink across the wrap from 31 back to 0
        cur_start_cfg = {2'b11, 5'd0};
        for (int f = 0; f < 40; f++) begin
            step(cur, 5'd5, 1'b1, 1'b1, "R10");
            step(cur, 5'd5, 1'b1, 1'b0, "R9");
            step(cur, 5'd5, 1'b0, 1'b0, "R7");
        end

        // R4: steady mode is unaffected by the frame count
        cur_start_cfg = {2'b00, 5'd0};
        for (int f = 0; f < 34; f++) begin
            step(cur, 5'd1, 1'b1, 1'b1, "R4");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule